// File: doc/BRIEF.md
# Interrupting GPIO Port

A bank of up to 32 general-purpose pins behind a small word-wide register bus. Software sets an output value and a direction for every pin and reads back the live pin levels. Pin inputs are resynchronised to the block clock before anything uses them.

Every pin can also raise an interrupt. A pin's interrupt is enabled by its mask bit. It is triggered by level or by edge, with either polarity. The block has several interrupt output wires. Each pin is steered to one of these wires through an 8-bit index in a routing register, or it is left unrouted. A wire goes high when any enabled pin steered to it fires. Edge triggers give a one-cycle pulse. Level triggers hold the wire high for as long as the condition lasts.

The bus has an address, a write strobe, write data and registered read data. A write takes effect on the clock edge where the strobe is sampled. Read data appears one cycle after the address.

Top module: `gpio_irq_port`

## Requirements
- R1: After reset, the pin-output, direction, mask, polarity, edge-select, route-enable and routing registers read 0, all `pin_oe` bits are 0, and `irq_o` is 0.
- R2: Registers are read and written as whole 32-bit words, with bit n belonging to pin n: output latch at 0x04, direction at 0x08, interrupt mask at 0x0C, polarity at 0x10, edge-select at 0x14, route-enable at 0x1C. A written value reads back unchanged, and `bus_rdata` shows the addressed register one cycle after the address is presented.
- R3: `pin_oe` equals the direction register, where 1 means output. `pin_o` carries the output latch on output pins and 0 on input pins.
- R4: Reading 0x00 returns the pin levels after a two-flop synchronizer. Writes to 0x00 change no register.
- R5: With the edge-select bit at 0, a masked-in pin is active while its synchronized level is low (polarity 0) or high (polarity 1).
- R6: With the edge-select bit at 1, a masked-in pin fires on a falling edge (polarity 0) or a rising edge (polarity 1) of its synchronized level. The result is exactly one cycle of activity per edge.
- R7: A pin whose mask bit is 0 never drives any interrupt output.
- R8: Routing word k at 0x20+4k holds the 8-bit target indexes of pins 4k..4k+3. Pin 4k sits in bits 31:24, then 23:16, 15:8, and pin 4k+3 sits in 7:0. A pin reaches output `irq_o[idx]` only if its route-enable bit is 1 and idx is less than the number of outputs; any other index leaves it unrouted.
- R9: Each interrupt output is the OR of all active, routed pins that target it, so pins can share an output.
- R10: The word at 0x18, and addresses beyond the last routing word, read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low reset |
| bus_addr | input | ADDR_W | Byte address of the word accessed |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| pin_i | input | N_LINES | Pin levels from the pads |
| pin_o | output | N_LINES | Output values for the pads |
| pin_oe | output | N_LINES | Pad output enables |
| irq_o | output | N_IRQ | Interrupt wires |

## Verification
The hardest case to reach is an edge-triggered pin whose single-cycle pulse has to appear on exactly the right wire. It must appear while other pins sit in level mode on the same wire, and while some pins carry routing indexes that lead nowhere. The stimulus writes random mask, polarity, edge and routing settings, with indexes drawn a little past the number of outputs. It then toggles random subsets of pins every cycle, and compares each wire against a per-cycle model of the synchronizer delay. Directed runs count the pulse length of a single edge and check out-of-range and disabled routes.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
   // word indexes (byte address / 4)
   localparam int unsigned W_LEVEL = 0;
   localparam int unsigned W_OUT   = 1;
   localparam int unsigned W_DIR   = 2;
   localparam int unsigned W_MASK  = 3;
   localparam int unsigned W_POL   = 4;
   localparam int unsigned W_EDGE  = 5;
   localparam int unsigned W_RSVD  = 6;
   localparam int unsigned W_REN   = 7;
   localparam int unsigned W_MAP0  = 8;

   localparam int unsigned IDX_BITS  = 8;
   localparam int unsigned PER_WORD  = 4;
   localparam int unsigned MAX_LINES = 32;

   // low bit of the routing byte for slot b of a routing word
   function automatic int unsigned slot_lsb(input int unsigned b);
      return 32 - IDX_BITS * (b + 1);
   endfunction
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
   parameter int unsigned N_LINES = 32
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [N_LINES-1:0] pin_i,
   output logic [N_LINES-1:0] lvl_o,
   output logic [N_LINES-1:0] prev_o
);
   logic [N_LINES-1:0] meta_q;
   logic [N_LINES-1:0] lvl_q;
   logic [N_LINES-1:0] prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         meta_q <= '0;
         lvl_q  <= '0;
         prev_q <= '0;
      end else begin
         meta_q <= pin_i;
         lvl_q  <= meta_q;
         prev_q <= lvl_q;
      end
   end

   assign lvl_o  = lvl_q;
   assign prev_o = prev_q;

   // cycles since reset, saturating, for the latency check
   logic [1:0] settle_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               settle_q <= '0;
      else if (settle_q != 2'd2) settle_q <= settle_q + 2'd1;
   end

   assert_sync_delay_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (settle_q == 2'd2) |-> (lvl_o == $past(pin_i, 2)));
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
   import gpio_irq_pkg::*;
#(
   parameter int unsigned N_LINES = 32,
   parameter int unsigned ADDR_W  = 8
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [ADDR_W-1:0]          bus_addr,
   input  logic                       bus_we,
   input  logic [31:0]                bus_wdata,
   output logic [31:0]                bus_rdata,
   input  logic [N_LINES-1:0]         lvl_i,
   output logic [N_LINES-1:0]         out_o,
   output logic [N_LINES-1:0]         dir_o,
   output logic [N_LINES-1:0]         mask_o,
   output logic [N_LINES-1:0]         pol_o,
   output logic [N_LINES-1:0]         edge_o,
   output logic [N_LINES-1:0]         ren_o,
   output logic [N_LINES*IDX_BITS-1:0] map_o
);
   localparam int unsigned WI_W  = ADDR_W - 2;
   localparam int unsigned N_MAP = (N_LINES + PER_WORD - 1) / PER_WORD;

   logic [WI_W-1:0] widx;
   logic [1:0]      unused_byte_sel;
   assign widx            = bus_addr[ADDR_W-1:2];
   assign unused_byte_sel = bus_addr[1:0];

   function automatic logic hit(input logic [WI_W-1:0] w, input int unsigned n);
      return w == WI_W'(n);
   endfunction

   logic [N_LINES-1:0] out_q, dir_q, mask_q, pol_q, edge_q, ren_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_q  <= '0;
         dir_q  <= '0;
         mask_q <= '0;
         pol_q  <= '0;
         edge_q <= '0;
         ren_q  <= '0;
      end else if (bus_we) begin
         if (hit(widx, W_OUT))  out_q  <= bus_wdata[N_LINES-1:0];
         if (hit(widx, W_DIR))  dir_q  <= bus_wdata[N_LINES-1:0];
         if (hit(widx, W_MASK)) mask_q <= bus_wdata[N_LINES-1:0];
         if (hit(widx, W_POL))  pol_q  <= bus_wdata[N_LINES-1:0];
         if (hit(widx, W_EDGE)) edge_q <= bus_wdata[N_LINES-1:0];
         if (hit(widx, W_REN))  ren_q  <= bus_wdata[N_LINES-1:0];
      end
   end

   // routing bytes, one per line, and their readback words
   logic [N_MAP*32-1:0] map_rd;

   for (genvar g = 0; g < N_MAP * PER_WORD; g++) begin : g_slot
      localparam int unsigned K   = g / PER_WORD;
      localparam int unsigned LSB = slot_lsb(g % PER_WORD);
      if (g < N_LINES) begin : g_line
         logic [IDX_BITS-1:0] idx_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               idx_q <= '0;
            else if (bus_we && hit(widx, W_MAP0 + K))
               idx_q <= bus_wdata[LSB +: IDX_BITS];
         end
         assign map_o[g*IDX_BITS +: IDX_BITS]   = idx_q;
         assign map_rd[K*32 + LSB +: IDX_BITS] = idx_q;
      end else begin : g_pad
         assign map_rd[K*32 + LSB +: IDX_BITS] = '0;
      end
   end

   logic [31:0] rd_val;
   always_comb begin
      rd_val = '0;
      if      (hit(widx, W_LEVEL)) rd_val = 32'(lvl_i);
      else if (hit(widx, W_OUT))   rd_val = 32'(out_q);
      else if (hit(widx, W_DIR))   rd_val = 32'(dir_q);
      else if (hit(widx, W_MASK))  rd_val = 32'(mask_q);
      else if (hit(widx, W_POL))   rd_val = 32'(pol_q);
      else if (hit(widx, W_EDGE))  rd_val = 32'(edge_q);
      else if (hit(widx, W_REN))   rd_val = 32'(ren_q);
      else begin
         for (int k = 0; k < int'(N_MAP); k++)
            if (hit(widx, W_MAP0 + k)) rd_val = map_rd[k*32 +: 32];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) bus_rdata <= '0;
      else        bus_rdata <= rd_val;
   end

   assign out_o  = out_q;
   assign dir_o  = dir_q;
   assign mask_o = mask_q;
   assign pol_o  = pol_q;
   assign edge_o = edge_q;
   assign ren_o  = ren_q;

   assert_out_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && hit(widx, W_OUT)) |=> (out_o == $past(bus_wdata[N_LINES-1:0])));
   assert_level_ro_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && hit(widx, W_LEVEL)) |=> ($stable(out_o) && $stable(mask_o) && $stable(dir_o)));
endmodule

// File: rtl/gpio_trig.sv
module gpio_trig #(
   parameter int unsigned N_LINES = 32
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [N_LINES-1:0] lvl_i,
   input  logic [N_LINES-1:0] prev_i,
   input  logic [N_LINES-1:0] mask_i,
   input  logic [N_LINES-1:0] pol_i,
   input  logic [N_LINES-1:0] edge_i,
   output logic [N_LINES-1:0] evt_o
);
   for (genvar i = 0; i < N_LINES; i++) begin : g_line
      logic rise, fall, lvl_hit, edge_hit;
      assign rise     = lvl_i[i] & ~prev_i[i];
      assign fall     = ~lvl_i[i] & prev_i[i];
      assign lvl_hit  = pol_i[i] ? lvl_i[i] : ~lvl_i[i];
      assign edge_hit = pol_i[i] ? rise : fall;
      assign evt_o[i] = mask_i[i] & (edge_i[i] ? edge_hit : lvl_hit);

      assert_edge_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
         (edge_i[i] && evt_o[i]) ##1 (edge_i[i] && $stable(pol_i[i])) |-> !evt_o[i]);
   end
endmodule

// File: rtl/gpio_route.sv
module gpio_route
   import gpio_irq_pkg::*;
#(
   parameter int unsigned N_LINES = 32,
   parameter int unsigned N_IRQ   = 4
) (
   input  logic [N_LINES-1:0]          evt_i,
   input  logic [N_LINES-1:0]          ren_i,
   input  logic [N_LINES*IDX_BITS-1:0] map_i,
   output logic [N_IRQ-1:0]            irq_o
);
   for (genvar j = 0; j < N_IRQ; j++) begin : g_out
      always_comb begin
         irq_o[j] = 1'b0;
         for (int i = 0; i < int'(N_LINES); i++)
            if (evt_i[i] && ren_i[i] && map_i[i*IDX_BITS +: IDX_BITS] == IDX_BITS'(j))
               irq_o[j] = 1'b1;
      end
   end
endmodule

// File: rtl/gpio_irq_port.sv
module gpio_irq_port
   import gpio_irq_pkg::*;
#(
   parameter int unsigned N_LINES = 32,
   parameter int unsigned N_IRQ   = 4,
   parameter int unsigned ADDR_W  = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [ADDR_W-1:0]  bus_addr,
   input  logic               bus_we,
   input  logic [31:0]        bus_wdata,
   output logic [31:0]        bus_rdata,
   input  logic [N_LINES-1:0] pin_i,
   output logic [N_LINES-1:0] pin_o,
   output logic [N_LINES-1:0] pin_oe,
   output logic [N_IRQ-1:0]   irq_o
);
   if (N_LINES < 1 || N_LINES > MAX_LINES) begin : g_bad_lines
      $error("N_LINES must lie in 1..32");
   end
   if (N_IRQ < 1 || N_IRQ > (1 << IDX_BITS)) begin : g_bad_irq
      $error("N_IRQ must lie in 1..256");
   end
   if (ADDR_W < 6) begin : g_bad_addr
      $error("ADDR_W must reach the routing words");
   end

   logic [N_LINES-1:0] lvl, prev, out_q, dir_q, mask_q, pol_q, edge_q, ren_q, evt;
   logic [N_LINES*IDX_BITS-1:0] map_q;

   gpio_sync #(.N_LINES(N_LINES)) u_sync (
      .clk(clk), .rst_n(rst_n), .pin_i(pin_i), .lvl_o(lvl), .prev_o(prev));

   gpio_regs #(.N_LINES(N_LINES), .ADDR_W(ADDR_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .lvl_i(lvl),
      .out_o(out_q), .dir_o(dir_q), .mask_o(mask_q), .pol_o(pol_q),
      .edge_o(edge_q), .ren_o(ren_q), .map_o(map_q));

   gpio_trig #(.N_LINES(N_LINES)) u_trig (
      .clk(clk), .rst_n(rst_n), .lvl_i(lvl), .prev_i(prev), .mask_i(mask_q),
      .pol_i(pol_q), .edge_i(edge_q), .evt_o(evt));

   gpio_route #(.N_LINES(N_LINES), .N_IRQ(N_IRQ)) u_route (
      .evt_i(evt), .ren_i(ren_q), .map_i(map_q), .irq_o(irq_o));

   assign pin_oe = dir_q;
   assign pin_o  = out_q & dir_q;

   assert_dir_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && bus_addr[ADDR_W-1:2] == (ADDR_W-2)'(W_DIR)) |=>
      (pin_oe == $past(bus_wdata[N_LINES-1:0])));
   assert_irq_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (|irq_o) |-> (|(mask_q & ren_q)));
   assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (irq_o == '0));
endmodule

// File: tb/gpio_irq_port_bench.sv
`timescale 1ns/1ps
module gpio_irq_port_bench;
   localparam int NL = 32;
   localparam int NI = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic        bus_we = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [NL-1:0] pin_i = '0;
   logic [NL-1:0] pin_o, pin_oe;
   logic [NI-1:0] irq_o;

   always #10 clk = ~clk;

   gpio_irq_port u_gpio_irq_port (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_i(pin_i),
      .pin_o(pin_o), .pin_oe(pin_oe), .irq_o(irq_o));

   int total = 0;
   int bad   = 0;
   bit done  = 0;

   logic [31:0] m_out = '0, m_dir = '0, m_mask = '0, m_pol = '0, m_edge = '0, m_ren = '0;
   logic [7:0]  m_map [NL];
   logic [31:0] p1 = '0, p2 = '0, p3 = '0;

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s act=%h exp=%h", req, act, exp);
      end
   endtask

   function automatic logic [NI-1:0] exp_irq(input logic [31:0] cur, input logic [31:0] prv);
      logic [NI-1:0] r = '0;
      for (int i = 0; i < NL; i++) begin
         logic lv, ed, ev;
         lv = m_pol[i] ? cur[i] : ~cur[i];
         ed = m_pol[i] ? (cur[i] & ~prv[i]) : (~cur[i] & prv[i]);
         ev = m_mask[i] & (m_edge[i] ? ed : lv);
         if (ev && m_ren[i] && m_map[i] < NI) r[m_map[i]] = 1'b1;
      end
      return r;
   endfunction

   function automatic logic [31:0] map_word(input int k);
      return {m_map[4*k], m_map[4*k+1], m_map[4*k+2], m_map[4*k+3]};
   endfunction

   task automatic shift();
      p3 = p2; p2 = p1; p1 = pin_i;
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      bus_addr = a; bus_wdata = d; bus_we = 1'b1;
      shift();
      @(negedge clk);
      bus_we = 1'b0;
      case (a)
         8'h04: m_out  = d;
         8'h08: m_dir  = d;
         8'h0C: m_mask = d;
         8'h10: m_pol  = d;
         8'h14: m_edge = d;
         8'h1C: m_ren  = d;
         default: if (a >= 8'h20 && a < 8'h40) begin
            for (int b = 0; b < 4; b++) m_map[(a - 8'h20) + b] = d[24 - 8*b +: 8];
         end
      endcase
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      bus_addr = a;
      shift();
      @(negedge clk);
      d = bus_rdata;
   endtask

   task automatic step(input string req, input logic [31:0] np);
      chk(req, 32'(irq_o), 32'(exp_irq(p2, p3)));
      pin_i = np;
      shift();
      @(negedge clk);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog act=timeout exp=finish");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      logic [31:0] d;
      logic [31:0] v;
      int cnt;
      void'($urandom(32'h5EED_0101));
      for (int i = 0; i < NL; i++) m_map[i] = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1: reset state
      chk("R1 oe", 32'(pin_oe), 0);
      chk("R1 irq", 32'(irq_o), 0);
      begin
         logic [7:0] regs [8] = '{8'h04, 8'h08, 8'h0C, 8'h10, 8'h14, 8'h1C, 8'h20, 8'h3C};
         for (int r = 0; r < 8; r++) begin
            rd(regs[r], d);
            chk("R1 reg", d, 0);
         end
      end

      // R2: write / readback
      begin
         logic [7:0] regs [6] = '{8'h04, 8'h08, 8'h0C, 8'h10, 8'h14, 8'h1C};
         for (int r = 0; r < 6; r++) begin
            v = $urandom;
            wr(regs[r], v);
            rd(regs[r], d);
            chk("R2 rw", d, v);
         end
         for (int k = 0; k < 8; k++) begin
            v = $urandom;
            wr(8'(8'h20 + 4*k), v);
            rd(8'(8'h20 + 4*k), d);
            chk("R8 map rw", d, map_word(k));
         end
      end

      // R3: pad drive
      chk("R3 oe", 32'(pin_oe), m_dir);
      chk("R3 out", 32'(pin_o), m_out & m_dir);
      wr(8'h08, 32'h0000_FFFF);
      chk("R3 oe2", 32'(pin_oe), 32'h0000_FFFF);
      chk("R3 out2", 32'(pin_o), m_out & 32'h0000_FFFF);

      // R4: level register
      for (int s = 0; s < 4; s++) step("R5 R6 hold", 32'hA5C3_0F96);
      rd(8'h00, d);
      chk("R4 level", d, 32'hA5C3_0F96);
      wr(8'h00, 32'h1234_5678);
      rd(8'h04, d);
      chk("R4 ro out", d, m_out);
      rd(8'h00, d);
      chk("R4 ro level", d, 32'hA5C3_0F96);

      // R10: empty words
      rd(8'h18, d); chk("R10 rsvd", d, 0);
      rd(8'h40, d); chk("R10 past", d, 0);
      rd(8'hFC, d); chk("R10 top", d, 0);

      // clear interrupt config
      wr(8'h0C, 0); wr(8'h10, 0); wr(8'h14, 0); wr(8'h1C, 0);
      for (int k = 0; k < 8; k++) wr(8'(8'h20 + 4*k), 0);

      // R6: rising edge on line 5 to irq 2, one pulse
      wr(8'h24, 32'h0002_0000);
      wr(8'h10, 32'h20); wr(8'h14, 32'h20); wr(8'h1C, 32'h20); wr(8'h0C, 32'h20);
      for (int s = 0; s < 4; s++) step("R6 idle", 0);
      cnt = 0;
      step("R6 rise", 32'h20);
      for (int s = 0; s < 6; s++) begin cnt += int'(irq_o[2]); step("R6 rise", 32'h20); end
      chk("R6 rise pulse", cnt, 1);
      wr(8'h10, 0);
      cnt = 0;
      step("R6 fall", 0);
      for (int s = 0; s < 6; s++) begin cnt += int'(irq_o[2]); step("R6 fall", 0); end
      chk("R6 fall pulse", cnt, 1);

      // R7: masked-out level line
      wr(8'h14, 0);
      wr(8'h0C, 0);
      for (int s = 0; s < 4; s++) step("R7", 0);
      chk("R7 masked", 32'(irq_o), 0);

      // R8: out-of-range index and disabled route, line 3 level high
      wr(8'h20, 32'h0000_0004);
      wr(8'h10, 32'h08); wr(8'h1C, 32'h08); wr(8'h0C, 32'h08);
      for (int s = 0; s < 4; s++) step("R8", 32'h08);
      chk("R8 range", 32'(irq_o), 0);
      wr(8'h20, 32'h0000_0001);
      for (int s = 0; s < 2; s++) step("R8", 32'h08);
      chk("R8 routed", 32'(irq_o), 32'h2);
      wr(8'h1C, 0);
      for (int s = 0; s < 2; s++) step("R8", 32'h08);
      chk("R8 disabled", 32'(irq_o), 0);

      // R5 R9: lines 7 and 9 level-high share irq 3
      wr(8'h24, 32'h0000_0003); wr(8'h28, 32'h0003_0000);
      wr(8'h10, 32'h280); wr(8'h14, 0); wr(8'h1C, 32'h280); wr(8'h0C, 32'h280);
      for (int s = 0; s < 3; s++) step("R9", 32'h080);
      chk("R9 a", 32'(irq_o), 32'h8);
      for (int s = 0; s < 3; s++) step("R9", 32'h200);
      chk("R9 b", 32'(irq_o), 32'h8);
      for (int s = 0; s < 3; s++) step("R5", 32'h000);
      chk("R5 level off", 32'(irq_o), 0);

      // random configurations and pin traffic: R5 R6 R7 R8 R9
      for (int blk = 0; blk < 6; blk++) begin
         wr(8'h0C, $urandom); wr(8'h10, $urandom); wr(8'h14, $urandom);
         wr(8'h1C, $urandom | $urandom);
         for (int k = 0; k < 8; k++)
            wr(8'(8'h20 + 4*k), {8'($urandom % 6), 8'($urandom % 6), 8'($urandom % 6), 8'($urandom % 6)});
         for (int s = 0; s < 300; s++)
            step("R5 R6 R7 R8 R9 random", pin_i ^ ($urandom & $urandom & $urandom));
      end

      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule